// File: doc/BRIEF.md
# Ternary Match Table Update Engine

This block rewrites one ternary entry in a match table that is stored as a set of small RAMs, one RAM per slice of the search key. Each RAM is addressed by its slice of the key and holds one bit per stored entry. The bit says whether that slice value satisfies the entry. Adding an entry sets its bit at every address that matches the entry's slice. Deleting an entry clears its bit at every address. Every other bit of each RAM word is left as it was.

A request carries a key value, a care mask, an entry index and an operation. The engine then walks one shared address counter across all addresses of every slice RAM at once. The RAMs are simple dual-port with a one-cycle read. In each cycle the engine writes back the word at the current address and reads the word at the next address, so a full pass takes one cycle per address plus one cycle to prime the first read.

One engine serves several match units that share the same slice layout. The high part of the entry index picks the unit whose RAMs are written. The low part picks the bit inside the RAM word. Lookups are declared invalid while a pass is running.

Top module: `tcam_update_engine`

## Requirements
- R1: After reset, busy and done are 0, lookup_ok is 1 and no write enable is asserted.
- R2: A request is taken only while busy is 0. A request raised while busy is 1 is dropped: it changes no RAM bit and starts no second pass.
- R3: On the cycle after a request is taken, busy is 1, ram_rd_addr is 0 and no write enable is asserted. On each of the next 2^SEG_W cycles the engine writes addresses 0, 1, … up to 2^SEG_W-1 in ascending order, and ram_rd_addr equals ram_wr_addr+1 modulo 2^SEG_W. Busy therefore lasts 2^SEG_W+1 cycles.
- R4: During the write cycles, exactly one bit of ram_wr_en is set: the bit selected by req_id divided by UNIT_WORDS (the high index bits). No other unit sees a write enable.
- R5: For an add (req_op=0), bit (req_id mod UNIT_WORDS) of slice s is written with 1 at address k exactly when ((k XOR key_s) AND mask_s) is 0, and with 0 otherwise. Here key_s is req_key[s*SEG_W +: SEG_W], mask_s is the same field of req_mask, and slice s occupies ram_wr_data[s*UNIT_WORDS +: UNIT_WORDS] and, for unit u, ram_rd_data[(u*SEGS+s)*UNIT_WORDS +: UNIT_WORDS].
- R6: For a delete (req_op=1), the target bit is written with 0 at every address of every slice.
- R7: All bits of the written word other than the target bit equal the word read from the selected unit at that address.
- R8: lookup_ok is 0 for exactly the cycles in which busy is 1.
- R9: done is a single-cycle pulse in the cycle after the last write. During that cycle busy is 0.
- R10: A slice whose mask field is all zero matches every address, so an add sets the target bit throughout that slice RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request strobe |
| req_key | input | KEY_W | Key value of the ternary entry |
| req_mask | input | KEY_W | Care mask, 0 marks a don't-care bit |
| req_id | input | ID_W | Entry index: unit in the high bits, bit position in the low bits |
| req_op | input | 1 | 0 = add, 1 = delete |
| ram_rd_data | input | NUM_UNITS*SEGS*UNIT_WORDS | Read data of every unit's slice RAMs |
| ram_rd_addr | output | SEG_W | Shared read address |
| ram_wr_addr | output | SEG_W | Shared write address |
| ram_wr_data | output | SEGS*UNIT_WORDS | Modified words, one field per slice |
| ram_wr_en | output | NUM_UNITS | Write enable per unit |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished pulse |
| lookup_ok | output | 1 | Match results of the units are valid |

## Verification
The assertions check on every cycle that the write enables are one-hot or idle and appear only while lookups are blocked. They also check that write addresses climb by one, that the read address leads the write address by one, that each pass opens with a read-only prime cycle, and that done is a lone pulse. Only the bench's scenarios can show that the right bits end up in the RAMs: the ternary hit pattern for exact, partly masked and fully masked slices, the clearing done by a delete, the preservation of neighbouring bits, and the dropping of a request that arrives mid-pass. These need a memory model and the index decode.

// File: rtl/tcam_upd_pkg.sv
package tcam_upd_pkg;

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_PRIME,
        UPD_SWEEP
    } upd_state_e;

endpackage

// File: rtl/upd_seg_merge.sv
module upd_seg_merge #(
    parameter int SEG_W      = 2,
    parameter int UNIT_WORDS = 4,
    parameter int BIT_W      = 2
) (
    input  logic [SEG_W-1:0]      addr,
    input  logic [SEG_W-1:0]      key_seg,
    input  logic [SEG_W-1:0]      mask_seg,
    input  logic [UNIT_WORDS-1:0] old_word,
    input  logic [BIT_W-1:0]      bitsel,
    input  logic                  op_del,
    output logic [UNIT_WORDS-1:0] new_word
);

    logic hit;

    always_comb begin
        hit      = ((addr ^ key_seg) & mask_seg) == '0;
        new_word = old_word;
        new_word[bitsel] = hit & ~op_del;
    end

endmodule

// File: rtl/upd_sweep_ctrl.sv
module upd_sweep_ctrl
    import tcam_upd_pkg::*;
#(
    parameter int KEY_W   = 8,
    parameter int SEG_W   = 2,
    parameter int ID_W    = 3,
    parameter int BIT_W   = 2,
    parameter int UNIT_IW = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [KEY_W-1:0]   req_key,
    input  logic [KEY_W-1:0]   req_mask,
    input  logic [ID_W-1:0]    req_id,
    input  logic               req_op,
    output upd_state_e         state,
    output logic [SEG_W-1:0]   cnt,
    output logic [UNIT_IW-1:0] unit,
    output logic [BIT_W-1:0]   bitsel,
    output logic [KEY_W-1:0]   key,
    output logic [KEY_W-1:0]   mask,
    output logic               op_del,
    output logic               done
);

    typedef struct packed {
        upd_state_e         state;
        logic [SEG_W-1:0]   cnt;
        logic [UNIT_IW-1:0] unit;
        logic [BIT_W-1:0]   bitsel;
        logic [KEY_W-1:0]   key;
        logic [KEY_W-1:0]   mask;
        logic               op_del;
        logic               done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            UPD_IDLE: begin
                if (req_valid) begin
                    st_d.state  = UPD_PRIME;
                    st_d.cnt    = '0;
                    st_d.unit   = UNIT_IW'(req_id >> BIT_W);
                    st_d.bitsel = BIT_W'(req_id);
                    st_d.key    = req_key;
                    st_d.mask   = req_mask;
                    st_d.op_del = req_op;
                end
            end
            UPD_PRIME: begin
                st_d.state = UPD_SWEEP;
            end
            UPD_SWEEP: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (&st_q.cnt) begin
                    st_d.state = UPD_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.state = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= UPD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign state  = st_q.state;
    assign cnt    = st_q.cnt;
    assign unit   = st_q.unit;
    assign bitsel = st_q.bitsel;
    assign key    = st_q.key;
    assign mask   = st_q.mask;
    assign op_del = st_q.op_del;
    assign done   = st_q.done;

endmodule

// File: rtl/tcam_update_engine.sv
module tcam_update_engine
    import tcam_upd_pkg::*;
#(
    parameter int KEY_W      = 8,
    parameter int SEG_W      = 2,
    parameter int UNIT_WORDS = 4,
    parameter int NUM_UNITS  = 2,
    localparam int SEGS      = KEY_W / SEG_W,
    localparam int ID_W      = (UNIT_WORDS * NUM_UNITS > 1) ? $clog2(UNIT_WORDS * NUM_UNITS) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [KEY_W-1:0]                     req_key,
    input  logic [KEY_W-1:0]                     req_mask,
    input  logic [ID_W-1:0]                      req_id,
    input  logic                                 req_op,
    input  logic [NUM_UNITS*SEGS*UNIT_WORDS-1:0] ram_rd_data,
    output logic [SEG_W-1:0]                     ram_rd_addr,
    output logic [SEG_W-1:0]                     ram_wr_addr,
    output logic [SEGS*UNIT_WORDS-1:0]           ram_wr_data,
    output logic [NUM_UNITS-1:0]                 ram_wr_en,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 lookup_ok
);

    localparam int BIT_W   = (UNIT_WORDS > 1) ? $clog2(UNIT_WORDS) : 1;
    localparam int UNIT_IW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam int SLAB    = SEGS * UNIT_WORDS;

    upd_state_e         state;
    logic [SEG_W-1:0]   cnt;
    logic [UNIT_IW-1:0] unit;
    logic [BIT_W-1:0]   bitsel;
    logic [KEY_W-1:0]   key;
    logic [KEY_W-1:0]   mask;
    logic               op_del;
    logic [SLAB-1:0]    sel_rd;

    upd_sweep_ctrl #(
        .KEY_W(KEY_W), .SEG_W(SEG_W), .ID_W(ID_W), .BIT_W(BIT_W), .UNIT_IW(UNIT_IW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
        .req_mask(req_mask), .req_id(req_id), .req_op(req_op), .state(state),
        .cnt(cnt), .unit(unit), .bitsel(bitsel), .key(key), .mask(mask),
        .op_del(op_del), .done(done)
    );

    always_comb begin
        sel_rd = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit == UNIT_IW'(u)) sel_rd = ram_rd_data[u*SLAB +: SLAB];
        end
    end

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        upd_seg_merge #(
            .SEG_W(SEG_W), .UNIT_WORDS(UNIT_WORDS), .BIT_W(BIT_W)
        ) u_merge (
            .addr     (cnt),
            .key_seg  (key[s*SEG_W +: SEG_W]),
            .mask_seg (mask[s*SEG_W +: SEG_W]),
            .old_word (sel_rd[s*UNIT_WORDS +: UNIT_WORDS]),
            .bitsel   (bitsel),
            .op_del   (op_del),
            .new_word (ram_wr_data[s*UNIT_WORDS +: UNIT_WORDS])
        );
    end

    always_comb begin
        ram_wr_en   = '0;
        ram_wr_addr = cnt;
        ram_rd_addr = '0;
        if (state == UPD_SWEEP) begin
            ram_rd_addr = cnt + 1'b1;
            for (int u = 0; u < NUM_UNITS; u++) begin
                ram_wr_en[u] = (unit == UNIT_IW'(u));
            end
        end
    end

    assign busy      = (state != UPD_IDLE);
    assign lookup_ok = (state == UPD_IDLE);

endmodule

// File: rtl/upd_engine_checker.sv
module upd_engine_checker #(
    parameter int SEG_W     = 2,
    parameter int NUM_UNITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEG_W-1:0]     ram_rd_addr,
    input logic [SEG_W-1:0]     ram_wr_addr,
    input logic [NUM_UNITS-1:0] ram_wr_en,
    input logic                 busy,
    input logic                 done,
    input logic                 lookup_ok
);

    assert_wr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_wr_en));

    assert_wr_blocks_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ram_wr_en) |-> (!lookup_ok && busy));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ram_wr_en) && $past(|ram_wr_en)) |-> (ram_wr_addr == SEG_W'($past(ram_wr_addr) + 1'b1)));

    assert_read_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ram_wr_en) |-> (ram_rd_addr == SEG_W'(ram_wr_addr + 1'b1)));

    assert_prime_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ram_wr_en == '0 && ram_rd_addr == '0));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && lookup_ok));

endmodule

bind tcam_update_engine upd_engine_checker #(
    .SEG_W(SEG_W), .NUM_UNITS(NUM_UNITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_rd_addr(ram_rd_addr), .ram_wr_addr(ram_wr_addr),
    .ram_wr_en(ram_wr_en), .busy(busy), .done(done), .lookup_ok(lookup_ok)
);

// File: tb/sim_tcam_update_engine.sv
`timescale 1ns/1ps
module sim_tcam_update_engine;

    localparam int KEY_W = 8;
    localparam int SEG_W = 2;
    localparam int UW    = 4;
    localparam int NU    = 2;
    localparam int P     = KEY_W / SEG_W;
    localparam int DEPTH = 1 << SEG_W;
    localparam int ID_W  = $clog2(UW * NU);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [KEY_W-1:0] req_key = '0;
    logic [KEY_W-1:0] req_mask = '0;
    logic [ID_W-1:0] req_id = '0;
    logic req_op = 1'b0;
    logic [NU*P*UW-1:0] ram_rd_data = '0;
    logic [SEG_W-1:0] ram_rd_addr, ram_wr_addr;
    logic [P*UW-1:0] ram_wr_data;
    logic [NU-1:0] ram_wr_en;
    logic busy, done, lookup_ok;

    logic [UW-1:0] mem  [NU][P][DEPTH];
    logic [UW-1:0] refm [NU][P][DEPTH];

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tcam_update_engine #(.KEY_W(KEY_W), .SEG_W(SEG_W), .UNIT_WORDS(UW), .NUM_UNITS(NU)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
        .req_mask(req_mask), .req_id(req_id), .req_op(req_op), .ram_rd_data(ram_rd_data),
        .ram_rd_addr(ram_rd_addr), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
        .ram_wr_en(ram_wr_en), .busy(busy), .done(done), .lookup_ok(lookup_ok)
    );

    // RAM model: one-cycle read, write at the clock edge
    always @(posedge clk) begin
        for (int u = 0; u < NU; u++) begin
            for (int s = 0; s < P; s++) begin
                if (ram_wr_en[u]) mem[u][s][ram_wr_addr] <= ram_wr_data[s*UW +: UW];
                ram_rd_data[(u*P+s)*UW +: UW] <= mem[u][s][ram_rd_addr];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_update(input logic [KEY_W-1:0] key, input logic [KEY_W-1:0] msk,
                              input int id, input logic op, input bit inject);
        int unit = id / UW;
        int bpos = id % UW;
        for (int s = 0; s < P; s++) begin
            for (int a = 0; a < DEPTH; a++) begin
                int ks = (key >> (s*SEG_W)) & (DEPTH-1);
                int ms = (msk >> (s*SEG_W)) & (DEPTH-1);
                refm[unit][s][a][bpos] = (op == 1'b0) && (((a ^ ks) & ms) == 0);
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_key = key; req_mask = msk; req_id = ID_W'(id); req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 prime busy", busy, 1);
        chk("R3 prime no write", ram_wr_en, 0);
        chk("R3 prime read addr", ram_rd_addr, 0);
        chk("R8 lookup blocked", lookup_ok, 0);
        for (int c = 1; c <= DEPTH; c++) begin
            @(negedge clk);
            if (inject && c == 2) begin
                req_valid = 1'b1; req_key = ~key; req_mask = '1;
                req_id = ID_W'(id ^ 5); req_op = ~op;
            end else begin
                req_valid = 1'b0;
            end
            chk("R3 busy in pass", busy, 1);
            chk("R8 lookup blocked", lookup_ok, 0);
            chk("R4 unit write enable", ram_wr_en, 1 << unit);
            chk("R3 write addr", ram_wr_addr, c - 1);
            chk("R3 read addr leads", ram_rd_addr, c % DEPTH);
            chk("R9 no early done", done, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 done pulse", done, 1);
        chk("R9 busy low at done", busy, 0);
        chk("R8 lookup restored", lookup_ok, 1);
        chk("R3 no write after pass", ram_wr_en, 0);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R2 no extra pass", busy, 0);
        for (int u = 0; u < NU; u++) begin
            for (int s = 0; s < P; s++) begin
                int bad = 0;
                for (int a = 0; a < DEPTH; a++) begin
                    if (mem[u][s][a] !== refm[u][s][a]) bad++;
                end
                chk($sformatf("R5 R6 R7 contents unit%0d seg%0d (mismatching addrs)", u, s), bad, 0);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int u = 0; u < NU; u++)
            for (int s = 0; s < P; s++)
                for (int a = 0; a < DEPTH; a++) begin
                    mem[u][s][a]  = UW'(u*7 + s*3 + a*5 + 9);
                    refm[u][s][a] = UW'(u*7 + s*3 + a*5 + 9);
                end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 lookup_ok after reset", lookup_ok, 1);
        chk("R1 no write after reset", ram_wr_en, 0);

        // R5: exact match, unit 0 bit 1
        run_update(8'hA5, 8'hFF, 1, 1'b0, 1'b0);
        // R10: low slices fully masked, unit 1 bit 2
        run_update(8'h3C, 8'hF0, 6, 1'b0, 1'b0);
        // R10: whole key don't-care, unit 1 bit 3
        run_update(8'h00, 8'h00, 7, 1'b0, 1'b0);
        // R5: mixed per-bit mask, unit 0 bit 0
        run_update(8'b01_10_11_01, 8'b10_01_11_00, 0, 1'b0, 1'b0);
        // R6: delete entry 1
        run_update(8'hA5, 8'hFF, 1, 1'b1, 1'b0);
        // R2: request raised mid-pass is dropped
        run_update(8'h5A, 8'hCC, 2, 1'b0, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R2 dropped request starts nothing", busy, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule